// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous memory with two fully independent access ports, called left and right. Each port has its own address, write data, byte enables, read/write select and a two-input chip enable. Both ports share one clock. Writes honour per-byte enables. Reads return registered data one clock after the address is presented.

The two highest words of the array double as a message channel between the ports. The top word is the left port's mailbox and the word below it is the right port's mailbox. When the opposite port writes a port's mailbox, that port's active-low interrupt is raised. The interrupt falls away once the owning port reads its own mailbox. Each port's interrupt is tracked by a small state machine with two states. `MBX_EMPTY` drives the interrupt high and `MBX_FULL` drives it low. The POST transition (peer write) moves `MBX_EMPTY` to `MBX_FULL`. The TAKE transition (owner read with no peer write in the same cycle) moves `MBX_FULL` to `MBX_EMPTY`. The REPOST case (peer write and owner read together) keeps `MBX_FULL`.

When both ports reach the same word in the same cycle and at least one of them writes, the block flags a collision on registered per-port busy outputs. These outputs are aligned with the read data of that access. Only flagging is done; the block does no arbitration beyond a fixed write priority.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: A port is enabled only while its `ce0_n` is low and its `ce1` is high. A disabled port writes nothing, leaves its `rdata` unchanged, and affects neither the mailboxes nor the busy flags.
- R2: On an enabled port, `rw` low requests a write and `rw` high requests a read. Read data appears on `rdata` at the clock edge after the one that samples the address.
- R3: A write updates only the byte lanes whose `be` bit is set. Lane k is data bits [8k+7:8k].
- R4: On a read, lanes whose `be` bit is clear return zero. On any cycle without a read on that port, `rdata` keeps its previous value.
- R5: Address DEPTH-1 is the left mailbox and address DEPTH-2 is the right mailbox. Both behave as ordinary storage for either port.
- R6: `l_int_n` goes low one cycle after the right port writes address DEPTH-1 with at least one byte enabled. `r_int_n` goes low one cycle after the left port writes DEPTH-2 in the same way. A port writing its own mailbox does not raise its own interrupt.
- R7: An interrupt returns high one cycle after its owner reads its own mailbox with at least one byte enabled. A read of that word by the other port does not clear it.
- R8: When a peer write to a mailbox and an owner read of that mailbox fall in the same cycle, the interrupt stays low.
- R9: When both ports write the same address in one cycle, lanes enabled by the left port take the left data. Lanes enabled only by the right port take the right data. Both busy outputs are high on the next cycle.
- R10: When one port reads an address that the other port writes in the same cycle, the reader receives the contents from before the write. Only the reader's busy output is high on the next cycle.
- R11: Two reads of the same address, or accesses to different addresses, raise no busy output.
- R12: While reset is active and after its release, both `rdata` are zero, both interrupts are high and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left read (1) / write (0) select |
| l_addr | input | ADDR_W | Left word address |
| l_be | input | BYTES | Left byte-lane enables |
| l_wdata | input | 8*BYTES | Left write data |
| l_rdata | output | 8*BYTES | Left registered read data |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| l_busy | output | 1 | Left collision flag |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right read (1) / write (0) select |
| r_addr | input | ADDR_W | Right word address |
| r_be | input | BYTES | Right byte-lane enables |
| r_wdata | input | 8*BYTES | Right write data |
| r_rdata | output | 8*BYTES | Right registered read data |
| r_int_n | output | 1 | Right mailbox interrupt, active low |
| r_busy | output | 1 | Right collision flag |

## Verification
Two functions meet in one cycle in two ways. A mailbox can be posted by the peer while its owner reads it. A write can also land on the very word the other port is reading or writing, which makes collision flagging coincide with data delivery. The bench drives both ports in the same cycle at mailbox addresses and at shared ordinary addresses. It then judges the interrupt level, the busy pair and the returned word one cycle later against a model built from the requirements. That model covers left-wins lane merging, old-data-on-read and set-wins interrupts.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [0:0] {
        MBX_EMPTY = 1'b0,
        MBX_FULL  = 1'b1
    } mbx_state_t;

    typedef struct packed {
        logic act;
        logic wr;
        logic rd;
    } port_req_t;

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode (
    input  logic                ce0_n,
    input  logic                ce1,
    input  logic                rw,
    output dpm_pkg::port_req_t  req
);
    always_comb begin
        req.act = ~ce0_n & ce1;
        req.wr  = req.act & ~rw;
        req.rd  = req.act &  rw;
    end
endmodule

// File: rtl/dpm_storage.sv
module dpm_storage #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  l_wr,
    input  logic                  l_rd,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [BYTES-1:0]      l_be,
    input  logic [8*BYTES-1:0]    l_wdata,
    output logic [8*BYTES-1:0]    l_rdata,
    input  logic                  r_wr,
    input  logic                  r_rd,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [BYTES-1:0]      r_be,
    input  logic [8*BYTES-1:0]    r_wdata,
    output logic [8*BYTES-1:0]    r_rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = 8 * BYTES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] l_mask;
    logic [DATA_W-1:0] r_mask;

    // Expand byte enables into bit masks, one lane per generate step.
    for (genvar k = 0; k < BYTES; k++) begin : g_mask
        assign l_mask[8*k +: 8] = {8{l_be[k]}};
        assign r_mask[8*k +: 8] = {8{r_be[k]}};
    end

    // Right lanes first, then left lanes: the later assignment wins,
    // so a lane both ports enable takes the left data.
    always_ff @(posedge clk) begin
        for (int k = 0; k < BYTES; k++) begin
            if (r_wr && r_be[k]) begin
                mem[r_addr][8*k +: 8] <= r_wdata[8*k +: 8];
            end
        end
        for (int k = 0; k < BYTES; k++) begin
            if (l_wr && l_be[k]) begin
                mem[l_addr][8*k +: 8] <= l_wdata[8*k +: 8];
            end
        end
    end

    // Registered reads see the contents before this edge's writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_rd) begin
                l_rdata <= mem[l_addr] & l_mask;
            end
            if (r_rd) begin
                r_rdata <= mem[r_addr] & r_mask;
            end
        end
    end
endmodule

// File: rtl/dpm_collide.sv
module dpm_collide #(
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dpm_pkg::port_req_t l_req,
    input  dpm_pkg::port_req_t r_req,
    input  logic [ADDR_W-1:0]  l_addr,
    input  logic [ADDR_W-1:0]  r_addr,
    output logic               l_busy,
    output logic               r_busy
);
    logic same_word;

    assign same_word = l_req.act && r_req.act && (l_addr == r_addr);

    // A port is flagged when the other port writes the word it touches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_busy <= 1'b0;
            r_busy <= 1'b0;
        end else begin
            l_busy <= same_word && r_req.wr;
            r_busy <= same_word && l_req.wr;
        end
    end
endmodule

// File: rtl/dpm_mailbox_fsm.sv
module dpm_mailbox_fsm #(
    parameter int              ADDR_W   = 6,
    parameter int              BYTES    = 4,
    parameter logic [ADDR_W-1:0] MBX_ADDR = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               peer_wr,
    input  logic [ADDR_W-1:0]  peer_addr,
    input  logic [BYTES-1:0]   peer_be,
    input  logic               own_rd,
    input  logic [ADDR_W-1:0]  own_addr,
    input  logic [BYTES-1:0]   own_be,
    output logic               int_n
);
    import dpm_pkg::*;

    mbx_state_t state, state_nx;
    logic       post, take;

    assign post = peer_wr && (peer_addr == MBX_ADDR) && (|peer_be);
    assign take = own_rd  && (own_addr  == MBX_ADDR) && (|own_be);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MBX_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MBX_EMPTY: if (post)          state_nx = MBX_FULL;
            MBX_FULL:  if (take && !post) state_nx = MBX_EMPTY;
            default:                      state_nx = MBX_EMPTY;
        endcase
    end

    always_comb begin
        int_n = (state != MBX_FULL);
    end
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  l_ce0_n,
    input  logic                  l_ce1,
    input  logic                  l_rw,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [BYTES-1:0]      l_be,
    input  logic [8*BYTES-1:0]    l_wdata,
    output logic [8*BYTES-1:0]    l_rdata,
    output logic                  l_int_n,
    output logic                  l_busy,
    input  logic                  r_ce0_n,
    input  logic                  r_ce1,
    input  logic                  r_rw,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [BYTES-1:0]      r_be,
    input  logic [8*BYTES-1:0]    r_wdata,
    output logic [8*BYTES-1:0]    r_rdata,
    output logic                  r_int_n,
    output logic                  r_busy
);
    localparam logic [ADDR_W-1:0] L_MBX = '1;
    localparam logic [ADDR_W-1:0] R_MBX = L_MBX - 1'b1;

    dpm_pkg::port_req_t l_req, r_req;

    dpm_port_decode u_l_dec (.ce0_n(l_ce0_n), .ce1(l_ce1), .rw(l_rw), .req(l_req));
    dpm_port_decode u_r_dec (.ce0_n(r_ce0_n), .ce1(r_ce1), .rw(r_rw), .req(r_req));

    dpm_storage #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .l_wr(l_req.wr), .l_rd(l_req.rd), .l_addr(l_addr), .l_be(l_be),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_wr(r_req.wr), .r_rd(r_req.rd), .r_addr(r_addr), .r_be(r_be),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    dpm_collide #(.ADDR_W(ADDR_W)) u_coll (
        .clk(clk), .rst_n(rst_n),
        .l_req(l_req), .r_req(r_req), .l_addr(l_addr), .r_addr(r_addr),
        .l_busy(l_busy), .r_busy(r_busy)
    );

    dpm_mailbox_fsm #(.ADDR_W(ADDR_W), .BYTES(BYTES), .MBX_ADDR(L_MBX)) u_l_mbx (
        .clk(clk), .rst_n(rst_n),
        .peer_wr(r_req.wr), .peer_addr(r_addr), .peer_be(r_be),
        .own_rd(l_req.rd), .own_addr(l_addr), .own_be(l_be),
        .int_n(l_int_n)
    );

    dpm_mailbox_fsm #(.ADDR_W(ADDR_W), .BYTES(BYTES), .MBX_ADDR(R_MBX)) u_r_mbx (
        .clk(clk), .rst_n(rst_n),
        .peer_wr(l_req.wr), .peer_addr(l_addr), .peer_be(l_be),
        .own_rd(r_req.rd), .own_addr(r_addr), .own_be(r_be),
        .int_n(r_int_n)
    );
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  l_ce0_n,
    input  logic                  l_ce1,
    input  logic                  l_rw,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [BYTES-1:0]      l_be,
    input  logic [8*BYTES-1:0]    l_wdata,
    input  logic [8*BYTES-1:0]    l_rdata,
    input  logic                  l_int_n,
    input  logic                  l_busy,
    input  logic                  r_ce0_n,
    input  logic                  r_ce1,
    input  logic                  r_rw,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [BYTES-1:0]      r_be,
    input  logic [8*BYTES-1:0]    r_wdata,
    input  logic [8*BYTES-1:0]    r_rdata,
    input  logic                  r_int_n,
    input  logic                  r_busy
);
    localparam logic [ADDR_W-1:0] TOP  = '1;
    localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

    logic la, ra, lw, rw, lr, rr, same, l_post, l_take, r_post, r_take;
    logic unused_data;

    assign la     = !l_ce0_n && l_ce1;
    assign ra     = !r_ce0_n && r_ce1;
    assign lw     = la && !l_rw;
    assign rw     = ra && !r_rw;
    assign lr     = la && l_rw;
    assign rr     = ra && r_rw;
    assign same   = la && ra && (l_addr == r_addr);
    assign l_post = rw && (r_addr == TOP)  && (|r_be);
    assign l_take = lr && (l_addr == TOP)  && (|l_be);
    assign r_post = lw && (l_addr == NEXT) && (|l_be);
    assign r_take = rr && (r_addr == NEXT) && (|r_be);
    assign unused_data = ^{l_wdata, r_wdata};

    assert_l_int_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        l_post |=> !l_int_n);
    assert_r_int_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_post |=> !r_int_n);
    assert_l_int_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_int_n) |-> $past(l_post));
    assert_l_int_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_take && !l_post) |=> l_int_n);
    assert_r_int_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_take && !r_post) |=> r_int_n);
    assert_int_repost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_take && l_post) |=> !l_int_n);
    assert_busy_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (same && lw && rw) |=> (l_busy && r_busy));
    assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy |-> $past(same && rw));
    assert_busy_reader_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (same && lr && rw) |=> (l_busy && !r_busy));
    assert_no_busy_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (same && lr && rr) |=> (!l_busy && !r_busy));
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lr |=> $stable(l_rdata));
    assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rr && !r_be[0]) |=> (r_rdata[7:0] == 8'h00));
endmodule

bind dpm_mailbox_ram dpm_checker #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (.*);

// File: tb/tb_dpm_mailbox_ram.sv
`timescale 1ns/1ps
module tb_dpm_mailbox_ram;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 8 * NB;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LM = AW'(DEPTH - 1);
    localparam logic [AW-1:0] RM = AW'(DEPTH - 2);
    localparam logic [1:0] ON  = 2'b10;  // {ce1, ce0_n}
    localparam logic [1:0] OFF = 2'b01;

    logic clk = 1'b0, rst_n = 1'b0;
    logic l_ce0_n = 1, l_ce1 = 0, l_rw = 1, r_ce0_n = 1, r_ce1 = 0, r_rw = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [NB-1:0] l_be = '0, r_be = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
    logic l_int_n, r_int_n, l_busy, r_busy;

    always #2 clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(AW), .BYTES(NB)) dut (.*);

    typedef struct {
        logic [DW-1:0] lrd, rrd;
        logic lb, rb, li, ri;
        string tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    int checks = 0, fails = 0;
    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] m_lrd = '0, m_rrd = '0;
    logic m_lfull = 0, m_rfull = 0;

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] msk(input logic [NB-1:0] be);
        logic [DW-1:0] m;
        for (int k = 0; k < NB; k++) m[8*k +: 8] = {8{be[k]}};
        return m;
    endfunction

    // Driver: applies one cycle on both ports and predicts the outputs.
    task automatic cyc(input logic [1:0] lc, input logic lrw, input logic [AW-1:0] la_,
                       input logic [NB-1:0] lbe, input logic [DW-1:0] lwd,
                       input logic [1:0] rc, input logic rrw, input logic [AW-1:0] ra_,
                       input logic [NB-1:0] rbe, input logic [DW-1:0] rwd, input string tag);
        logic la, ra, lw, rw, lr, rr, same, lset, lclr, rset, rclr;
        exp_t x;
        {l_ce1, l_ce0_n} = lc; l_rw = lrw; l_addr = la_; l_be = lbe; l_wdata = lwd;
        {r_ce1, r_ce0_n} = rc; r_rw = rrw; r_addr = ra_; r_be = rbe; r_wdata = rwd;
        la = lc == ON; ra = rc == ON;
        lw = la && !lrw; rw = ra && !rrw; lr = la && lrw; rr = ra && rrw;
        same = la && ra && (la_ == ra_);
        if (lr) m_lrd = mdl[la_] & msk(lbe);
        if (rr) m_rrd = mdl[ra_] & msk(rbe);
        for (int k = 0; k < NB; k++) if (rw && rbe[k]) mdl[ra_][8*k +: 8] = rwd[8*k +: 8];
        for (int k = 0; k < NB; k++) if (lw && lbe[k]) mdl[la_][8*k +: 8] = lwd[8*k +: 8];
        lset = rw && ra_ == LM && |rbe; lclr = lr && la_ == LM && |lbe;
        rset = lw && la_ == RM && |lbe; rclr = rr && ra_ == RM && |rbe;
        m_lfull = lset ? 1'b1 : (lclr ? 1'b0 : m_lfull);
        m_rfull = rset ? 1'b1 : (rclr ? 1'b0 : m_rfull);
        x.lrd = m_lrd; x.rrd = m_rrd;
        x.lb = same && rw; x.rb = same && lw;
        x.li = !m_lfull; x.ri = !m_rfull; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
    endtask

    task automatic lwr(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] d, input string t);
        cyc(ON, 0, a, be, d, OFF, 1, '0, '0, '0, t);
    endtask
    task automatic rwr(input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [DW-1:0] d, input string t);
        cyc(OFF, 1, '0, '0, '0, ON, 0, a, be, d, t);
    endtask
    task automatic lrd(input logic [AW-1:0] a, input logic [NB-1:0] be, input string t);
        cyc(ON, 1, a, be, '0, OFF, 1, '0, '0, '0, t);
    endtask
    task automatic rrd(input logic [AW-1:0] a, input logic [NB-1:0] be, input string t);
        cyc(OFF, 1, '0, '0, '0, ON, 1, a, be, '0, t);
    endtask
    task automatic idle(input string t);
        cyc(OFF, 1, '0, '0, '0, OFF, 1, '0, '0, '0, t);
    endtask

    // Monitor: compares one predicted item per cycle, after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "l_rdata", l_rdata, e.lrd);
            chk(e.tag, "r_rdata", r_rdata, e.rrd);
            chk(e.tag, "l_busy", DW'(l_busy), DW'(e.lb));
            chk(e.tag, "r_busy", DW'(r_busy), DW'(e.rb));
            chk(e.tag, "l_int_n", DW'(l_int_n), DW'(e.li));
            chk(e.tag, "r_int_n", DW'(r_int_n), DW'(e.ri));
        end
    end

    initial begin
        #(4.0 * 200000);
        fails++; checks++;
        $display("FAIL watchdog act=running exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R12: reset values while reset is held
        chk("R12", "l_rdata", l_rdata, '0);
        chk("R12", "r_rdata", r_rdata, '0);
        chk("R12", "ints", DW'({l_int_n, r_int_n}), DW'(2'b11));
        chk("R12", "busy", DW'({l_busy, r_busy}), '0);
        rst_n = 1'b1;
        idle("R12");
        // Initialise words touched later with full writes (R2)
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) lwr(AW'(i), '1, DW'(32'hA0A0_0000 + i), "R2");
            else            rwr(AW'(i), '1, DW'(32'hB0B0_0000 + i), "R2");
        end
        lwr(LM, '1, 32'h0, "R2"); rwr(RM, '1, 32'h0, "R2");  // own mailbox: R6 no self-interrupt
        for (int i = 0; i < 8; i++) begin
            lrd(AW'(i), '1, "R2");
            rrd(AW'(i), '1, "R2");
        end
        // R3: partial lane writes
        lwr(2, 4'b0101, 32'h1122_3344, "R3");
        rwr(3, 4'b1000, 32'hDEAD_BEEF, "R3");
        lrd(2, '1, "R3"); rrd(3, '1, "R3");
        // R4: disabled read lanes are zero, rdata holds while idle
        lrd(1, 4'b0110, "R4"); rrd(0, 4'b0001, "R4");
        idle("R4"); idle("R4");
        // R1: partial enables do nothing
        cyc(2'b00, 0, 4, '1, 32'hFFFF_FFFF, 2'b11, 0, 4, '1, 32'hEEEE_EEEE, "R1");
        cyc(2'b11, 1, 4, '1, '0, 2'b00, 1, 4, '1, '0, "R1");
        cyc(2'b01, 0, LM, '1, 32'h1, 2'b11, 0, LM, '1, 32'h2, "R1");
        lrd(4, '1, "R1");
        // R6/R7/R5: right posts to left mailbox
        rwr(LM, 4'b0011, 32'hCAFE_1234, "R6");
        rrd(LM, '1, "R7");                 // peer read does not clear
        lrd(LM, 4'b0000, "R7");            // no lanes: does not clear
        lrd(LM, '1, "R5");                 // clears, returns message
        idle("R7");
        // R6/R7: left posts to right mailbox
        lwr(RM, 4'b1000, 32'h5A00_0000, "R6");
        idle("R6");
        rrd(RM, '1, "R7");
        // R8: post and take in the same cycle
        rwr(LM, '1, 32'h0000_0001, "R8");
        cyc(ON, 1, LM, '1, '0, ON, 0, LM, '1, 32'h0000_0002, "R8");
        lrd(LM, '1, "R8");
        cyc(ON, 0, RM, '1, 32'h77, ON, 1, RM, '1, '0, "R8");
        rrd(RM, '1, "R8");
        // R9: both write one word, overlapping lanes
        cyc(ON, 0, 5, 4'b0011, 32'h1111_1111, ON, 0, 5, 4'b1110, 32'h2222_2222, "R9");
        lrd(5, '1, "R9");
        // R10: read against write on one word, both directions
        cyc(ON, 1, 6, '1, '0, ON, 0, 6, '1, 32'h6666_6666, "R10");
        cyc(ON, 0, 7, '1, 32'h7777_7777, ON, 1, 7, '1, '0, "R10");
        lrd(7, '1, "R10"); rrd(6, '1, "R10");
        // R11: shared reads and disjoint writes raise nothing
        cyc(ON, 1, 6, '1, '0, ON, 1, 6, '1, '0, "R11");
        cyc(ON, 0, 0, '1, 32'h0F0F_0F0F, ON, 0, 1, '1, 32'hF0F0_F0F0, "R11");
        cyc(ON, 1, 1, '1, '0, ON, 1, 0, '1, '0, "R11");
        idle("R11"); idle("R11");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule